// File: doc/BRIEF.md
# Transfer-Count and Completion Engine

This block owns the length and completion side of a block-data transfer run under DMA control. Software writes the desired byte count as two byte-wide registers. Any command with its top bit set loads those bytes into a readable count. When the command is the transfer command, the engine also works out how many bytes to move. That number is the programmed count, limited by what is left in the current bus phase. In command-capture mode the cap is a fixed 32 bytes instead.

The transfer then moves in chunks. Each time the target offers a buffer, the engine asks a simple memory request/grant port for the smaller of the bytes still owed and the bytes in that buffer. The direction comes from the sign of the remaining phase size. Completion is posted at once if a chunk leaves part of the target's buffer unused. If the buffer runs dry exactly, completion waits for the next buffer or for the target to finish the command, depending on direction. On completion the engine sets the terminal-count status bit, records the bus-service reason, clears the readable count and raises the interrupt.

Top module: `xfer_count_engine`

## Requirements
- R1: The programmed length is {high byte, low byte} from the two count-write ports (low byte in bits 7:0). A programmed value of zero means 65536 bytes.
- R2: Any command whose bit 7 is 1 copies the written count bytes into `cnt_rd`. A command with bit 7 at 0 leaves `cnt_rd` unchanged.
- R3: A write to either count byte clears the terminal-count bit, `stat_o[4]`.
- R4: Command code 0x90 (bit 7 set, low seven bits 0x10), issued while idle, starts a transfer. It sets `busy_o` and clears `stat_o[4]`. The amount owed is min(programmed length, |phase_size|), or min(programmed length, 32) when `capture_mode` is 1.
- R5: Each memory request has length min(bytes owed, bytes in the offered target buffer). The request stays asserted with a stable length until granted. No request is made while the buffer is empty.
- R6: A granted chunk that leaves part of the target buffer unused completes the transfer in the same clock.
- R7: Completion sets `stat_o[4]`, sets `reason_o` to 0x10, clears `cnt_rd` and `busy_o`, and raises `irq_o`. `stat_o[7]` mirrors `irq_o`, and `irq_ack` lowers it.
- R8: When a chunk exactly empties the buffer, three cases apply. A target-to-host transfer with nothing owed but phase bytes still left completes at once. A host-to-target transfer waits, and completes on the next offer if nothing is owed. Otherwise the engine waits for the target.
- R9: A `tgt_done` pulse zeroes all remaining lengths and sets `stat_o[2:0]` to 3 (status phase). It then performs the R7 completion actions.
- R10: A negative `phase_size` (two's complement) means host-to-target and drives `mem_store` to 0. A zero or positive size means target-to-host with `mem_store` at 1.
- R11: A transfer command issued while `busy_o` is 1 does not restart or change the running transfer.
- R12: In capture mode the engine makes one memory fetch of the capped length, needs no target buffer, and completes with `reason_o` set to 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_lo_wr | input | 1 | Write strobe, low count byte |
| cnt_mid_wr | input | 1 | Write strobe, high count byte |
| cnt_wdata | input | BYTE_W | Count byte write data |
| cmd_valid | input | 1 | Command issue strobe |
| cmd_code | input | 8 | Command code; bit 7 selects DMA |
| capture_mode | input | 1 | Command-capture mode for the next start |
| phase_size | input | PHASE_W | Signed bytes left in the phase |
| tgt_offer | input | 1 | Target offers a buffer |
| tgt_len | input | 2*BYTE_W+1 | Length of the offered buffer |
| tgt_done | input | 1 | Target finished the command |
| mem_gnt | input | 1 | Memory grant for the pending chunk |
| irq_ack | input | 1 | Lowers the interrupt |
| mem_req | output | 1 | Memory chunk request |
| mem_len | output | 2*BYTE_W+1 | Chunk length in bytes |
| mem_store | output | 1 | 1: write to memory, 0: read from memory |
| cnt_rd | output | 2*BYTE_W | Readable count |
| stat_o | output | 8 | Status: bit 7 irq, bit 4 terminal count, bits 2:0 phase |
| reason_o | output | 8 | Interrupt reason |
| irq_o | output | 1 | Interrupt |
| busy_o | output | 1 | Transfer in progress |

## Verification
The properties assume several things about the inputs. `mem_gnt` arrives only against a pending request. A buffer offer that lands while a request is pending is simply not taken. A count write, a DMA command and `tgt_done` are not used together in the same clock in ways the properties exclude through their antecedents. The bench drives every strobe for exactly one clock on the falling edge. It grants only after it has seen `mem_req` and checked `mem_len`. It sends `tgt_done` only while no grant is in flight, and it renews the target buffer before each table transfer so no stale length carries over.

// File: rtl/xce_pkg.sv
package xce_pkg;
    // transfer command in the low seven bits of a command code
    localparam logic [6:0] OP_XFER    = 7'h10;
    // interrupt reason codes
    localparam logic [7:0] REASON_BUS = 8'h10;
    localparam logic [7:0] REASON_CAP = 8'h18;
    // phase code posted when the target ends the command
    localparam logic [2:0] PH_STATUS  = 3'd3;
endpackage

// File: rtl/xce_count_regs.sv
module xce_count_regs #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lo_wr,
    input  logic                  mid_wr,
    input  logic [BYTE_W-1:0]     wdata,
    input  logic                  reload,
    input  logic                  clear,
    output logic [2*BYTE_W-1:0]   rd_cnt,
    output logic [2*BYTE_W:0]     wr_len
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] mid;
        logic [CNT_W-1:0]  rd;
    } cnt_t;

    cnt_t q, d;
    logic [CNT_W-1:0] written;

    assign written = {q.mid, q.lo};

    always_comb begin
        d = q;
        if (lo_wr)  d.lo = wdata;
        if (mid_wr) d.mid = wdata;
        if (reload)     d.rd = written;
        else if (clear) d.rd = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_cnt = q.rd;
    // an all-zero count stands for the full range
    assign wr_len = (written == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, written};
endmodule

// File: rtl/xce_len_clamp.sv
module xce_len_clamp #(
    parameter int LEN_W   = 17,
    parameter int PHASE_W = 24,
    parameter int CAP_LEN = 32
) (
    input  logic [LEN_W-1:0]   req_len,
    input  logic [PHASE_W-1:0] phase,
    input  logic               capture,
    output logic [LEN_W-1:0]   eff_len
);
    logic [PHASE_W-1:0] mag;
    logic [PHASE_W-1:0] lim;
    logic [PHASE_W-1:0] ext_len;

    always_comb begin
        mag     = phase[PHASE_W-1] ? (~phase + 1'b1) : phase;
        lim     = capture ? PHASE_W'(CAP_LEN) : mag;
        ext_len = PHASE_W'(req_len);
        eff_len = (ext_len < lim) ? req_len : LEN_W'(lim);
    end
endmodule

// File: rtl/xfer_count_engine.sv
module xfer_count_engine #(
    parameter int BYTE_W  = 8,
    parameter int PHASE_W = 24,
    parameter int CAP_LEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cnt_lo_wr,
    input  logic                 cnt_mid_wr,
    input  logic [BYTE_W-1:0]    cnt_wdata,
    input  logic                 cmd_valid,
    input  logic [7:0]           cmd_code,
    input  logic                 capture_mode,
    input  logic [PHASE_W-1:0]   phase_size,
    input  logic                 tgt_offer,
    input  logic [2*BYTE_W:0]    tgt_len,
    input  logic                 tgt_done,
    input  logic                 mem_gnt,
    input  logic                 irq_ack,
    output logic                 mem_req,
    output logic [2*BYTE_W:0]    mem_len,
    output logic                 mem_store,
    output logic [2*BYTE_W-1:0]  cnt_rd,
    output logic [7:0]           stat_o,
    output logic [7:0]           reason_o,
    output logic                 irq_o,
    output logic                 busy_o
);
    import xce_pkg::*;

    localparam int CNT_W = 2 * BYTE_W;
    localparam int LEN_W = CNT_W + 1;

    typedef struct packed {
        logic               busy;
        logic               capture;
        logic               to_tgt;
        logic               req;
        logic               tc;
        logic               irq;
        logic [2:0]         ph;
        logic [7:0]         reason;
        logic [LEN_W-1:0]   left;
        logic [LEN_W-1:0]   avail;
        logic [LEN_W-1:0]   chunk;
        logic [PHASE_W-1:0] phase;
    } eng_t;

    eng_t q, d;

    logic               fin;
    logic [7:0]         fin_reason;
    logic               start;
    logic               reload;
    logic [LEN_W-1:0]   wr_len;
    logic [LEN_W-1:0]   eff_len;
    logic [LEN_W-1:0]   avail_now;
    logic [LEN_W-1:0]   left_new;
    logic [LEN_W-1:0]   avail_new;
    logic [PHASE_W-1:0] phase_new;
    logic [PHASE_W-1:0] chunk_ext;

    assign reload = cmd_valid && cmd_code[7];
    assign start  = reload && (cmd_code[6:0] == OP_XFER) && !q.busy;

    xce_count_regs #(.BYTE_W(BYTE_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .lo_wr  (cnt_lo_wr),
        .mid_wr (cnt_mid_wr),
        .wdata  (cnt_wdata),
        .reload (reload),
        .clear  (fin),
        .rd_cnt (cnt_rd),
        .wr_len (wr_len)
    );

    xce_len_clamp #(.LEN_W(LEN_W), .PHASE_W(PHASE_W), .CAP_LEN(CAP_LEN)) u_clamp (
        .req_len (wr_len),
        .phase   (phase_size),
        .capture (capture_mode),
        .eff_len (eff_len)
    );

    assign chunk_ext = PHASE_W'(q.chunk);
    // a fresh offer is taken only while no chunk is in flight
    assign avail_now = (tgt_offer && !q.req) ? tgt_len : q.avail;

    always_comb begin
        d          = q;
        fin        = 1'b0;
        fin_reason = REASON_BUS;
        left_new   = q.left - q.chunk;
        avail_new  = q.avail - q.chunk;
        phase_new  = q.to_tgt ? (q.phase + chunk_ext) : (q.phase - chunk_ext);

        if (cnt_lo_wr || cnt_mid_wr) d.tc = 1'b0;
        if (irq_ack)                 d.irq = 1'b0;
        d.avail = avail_now;

        if (tgt_done) begin
            d.left  = '0;
            d.avail = '0;
            d.phase = '0;
            d.ph    = PH_STATUS;
            fin     = 1'b1;
        end else if (start) begin
            d.busy    = 1'b1;
            d.tc      = 1'b0;
            d.capture = capture_mode;
            d.to_tgt  = phase_size[PHASE_W-1];
            d.phase   = phase_size;
            d.left    = eff_len;
            d.req     = 1'b0;
        end else if (q.busy) begin
            if (q.req) begin
                if (mem_gnt) begin
                    d.req = 1'b0;
                    if (q.capture) begin
                        d.left     = '0;
                        fin        = 1'b1;
                        fin_reason = REASON_CAP;
                    end else begin
                        d.left  = left_new;
                        d.avail = avail_new;
                        d.phase = phase_new;
                        if (avail_new != '0) begin
                            fin = 1'b1;
                        end else if (!q.to_tgt && (left_new == '0) &&
                                     !phase_new[PHASE_W-1] && (phase_new != '0)) begin
                            fin = 1'b1;
                        end
                    end
                end
            end else if (q.capture) begin
                d.req   = 1'b1;
                d.chunk = q.left;
            end else if (avail_now != '0) begin
                if (q.left == '0) begin
                    fin = 1'b1;
                end else begin
                    d.req   = 1'b1;
                    d.chunk = (q.left < avail_now) ? q.left : avail_now;
                end
            end
        end

        if (fin) begin
            d.busy   = 1'b0;
            d.req    = 1'b0;
            d.tc     = 1'b1;
            d.irq    = 1'b1;
            d.reason = fin_reason;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req   = q.req;
    assign mem_len   = q.chunk;
    assign mem_store = !q.to_tgt && !q.capture;
    assign stat_o    = {q.irq, 2'b00, q.tc, 1'b0, q.ph};
    assign reason_o  = q.reason;
    assign irq_o     = q.irq;
    assign busy_o    = q.busy;
endmodule

// File: rtl/xce_checker.sv
module xce_checker #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cnt_lo_wr,
    input logic                cnt_mid_wr,
    input logic [BYTE_W-1:0]   cnt_wdata,
    input logic                cmd_valid,
    input logic [7:0]          cmd_code,
    input logic                tgt_done,
    input logic                mem_gnt,
    input logic                mem_req,
    input logic [2*BYTE_W:0]   mem_len,
    input logic [2*BYTE_W-1:0] cnt_rd,
    input logic [7:0]          stat_o,
    input logic [7:0]          reason_o,
    input logic                irq_o,
    input logic                busy_o
);
    localparam int CNT_W = 2 * BYTE_W;
    localparam logic [CNT_W:0] MAX_LEN = {1'b1, {CNT_W{1'b0}}};

    logic [BYTE_W-1:0] sh_lo, sh_mid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_lo  <= '0;
            sh_mid <= '0;
        end else begin
            if (cnt_lo_wr)  sh_lo  <= cnt_wdata;
            if (cnt_mid_wr) sh_mid <= cnt_wdata;
        end
    end

    AST_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_len <= MAX_LEN)); // R1

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code[7] && !cnt_lo_wr && !cnt_mid_wr)
        |=> (cnt_rd == {sh_mid, sh_lo})); // R2

    AST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 8'h90 && !busy_o && !tgt_done)
        |=> (busy_o && !stat_o[4])); // R4

    AST_REQ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_len != '0)); // R5

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !tgt_done) |=> (mem_req && $stable(mem_len))); // R5

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req); // R5

    AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (stat_o[4] && !busy_o &&
                          (reason_o == 8'h10 || reason_o == 8'h18))); // R7

    AST_TGT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_done && !(cmd_valid && cmd_code[7]))
        |=> (stat_o[2:0] == 3'd3 && stat_o[4] && irq_o && !busy_o &&
             !mem_req && cnt_rd == '0)); // R9
endmodule

bind xfer_count_engine xce_checker #(.BYTE_W(BYTE_W)) u_xce_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_lo_wr  (cnt_lo_wr),
    .cnt_mid_wr (cnt_mid_wr),
    .cnt_wdata  (cnt_wdata),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .tgt_done   (tgt_done),
    .mem_gnt    (mem_gnt),
    .mem_req    (mem_req),
    .mem_len    (mem_len),
    .cnt_rd     (cnt_rd),
    .stat_o     (stat_o),
    .reason_o   (reason_o),
    .irq_o      (irq_o),
    .busy_o     (busy_o)
);

// File: tb/tb_xfer_count_engine.sv
module tb_xfer_count_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_lo_wr = 1'b0, cnt_mid_wr = 1'b0;
    logic [7:0]  cnt_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic        capture_mode = 1'b0;
    logic [23:0] phase_size = '0;
    logic        tgt_offer = 1'b0;
    logic [16:0] tgt_len = '0;
    logic        tgt_done = 1'b0;
    logic        mem_gnt = 1'b0;
    logic        irq_ack = 1'b0;
    logic        mem_req, mem_store, irq_o, busy_o;
    logic [16:0] mem_len;
    logic [15:0] cnt_rd;
    logic [7:0]  stat_o, reason_o;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    xfer_count_engine dut (
        .clk(clk), .rst_n(rst_n), .cnt_lo_wr(cnt_lo_wr), .cnt_mid_wr(cnt_mid_wr),
        .cnt_wdata(cnt_wdata), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .capture_mode(capture_mode), .phase_size(phase_size), .tgt_offer(tgt_offer),
        .tgt_len(tgt_len), .tgt_done(tgt_done), .mem_gnt(mem_gnt), .irq_ack(irq_ack),
        .mem_req(mem_req), .mem_len(mem_len), .mem_store(mem_store), .cnt_rd(cnt_rd),
        .stat_o(stat_o), .reason_o(reason_o), .irq_o(irq_o), .busy_o(busy_o)
    );

    typedef struct packed {
        logic [7:0]  lo;
        logic [7:0]  mid;
        logic [23:0] ph;
        logic        cap;
        logic [16:0] offer;
        logic [16:0] exp_len;
        logic        exp_store;
        logic [7:0]  exp_reason;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'h20, 8'h00, 24'd100,     1'b0, 17'd200,    17'd32,    1'b1, 8'h10},
        '{8'h00, 8'h01, 24'hFFFC18,  1'b0, 17'd2000,   17'd256,   1'b0, 8'h10},
        '{8'h00, 8'h00, 24'd70000,   1'b0, 17'd131071, 17'd65536, 1'b1, 8'h10},
        '{8'h50, 8'h00, 24'd10,      1'b0, 17'd40,     17'd10,    1'b1, 8'h10},
        '{8'h00, 8'h02, 24'd5,       1'b1, 17'd0,      17'd32,    1'b0, 8'h18},
        '{8'h05, 8'h00, 24'd900,     1'b1, 17'd0,      17'd5,     1'b0, 8'h18},
        '{8'hFF, 8'hFF, 24'hFFFFFD,  1'b0, 17'd100,    17'd3,     1'b0, 8'h10}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_cnt(input logic [7:0] lo, input logic [7:0] mid);
        cnt_lo_wr = 1'b1; cnt_wdata = lo;
        @(negedge clk);
        cnt_lo_wr = 1'b0; cnt_mid_wr = 1'b1; cnt_wdata = mid;
        @(negedge clk);
        cnt_mid_wr = 1'b0;
    endtask

    task automatic issue(input logic [7:0] code);
        cmd_valid = 1'b1; cmd_code = code;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic offer(input logic [16:0] len);
        tgt_offer = 1'b1; tgt_len = len;
        @(negedge clk);
        tgt_offer = 1'b0;
    endtask

    task automatic pulse_done();
        tgt_done = 1'b1;
        @(negedge clk);
        tgt_done = 1'b0;
    endtask

    task automatic grant();
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic wait_req(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            if (mem_req) seen = 1'b1;
            else @(negedge clk);
        end
        chk(req, {31'd0, seen}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R7 reset stat", stat_o, 0);
        chk("R7 reset irq", irq_o, 0);
        chk("R4 reset busy", busy_o, 0);
        chk("R5 reset req", mem_req, 0);
        chk("R2 reset cnt", cnt_rd, 0);

        // R2: reload only on commands with bit 7
        wr_cnt(8'h34, 8'h12);
        chk("R2 no reload on write", cnt_rd, 0);
        issue(8'h00);
        chk("R2 non-dma command", cnt_rd, 0);
        issue(8'h80);
        chk("R2 dma command reload", cnt_rd, 16'h1234);
        chk("R4 non-transfer command idle", busy_o, 0);

        // table of full transfers
        for (int k = 0; k < NV; k++) begin
            phase_size   = VECS[k].ph;
            capture_mode = VECS[k].cap;
            wr_cnt(VECS[k].lo, VECS[k].mid);
            if (VECS[k].offer != 0) offer(VECS[k].offer);
            issue(8'h90);
            capture_mode = 1'b0;
            chk("R4 busy after start", busy_o, 1);
            chk("R4 tc cleared at start", stat_o[4], 0);
            wait_req("R5 request seen");
            chk("R1 R4 R12 chunk length", mem_len, VECS[k].exp_len);
            chk("R10 direction", mem_store, VECS[k].exp_store);
            grant();
            chk("R6 R12 immediate irq", irq_o, 1);
            chk("R7 reason", reason_o, VECS[k].exp_reason);
            chk("R7 tc set", stat_o[4], 1);
            chk("R7 stat irq bit", stat_o[7], 1);
            chk("R7 count cleared", cnt_rd, 0);
            chk("R7 busy cleared", busy_o, 0);
            ack();
            chk("R7 irq ack", irq_o, 0);
        end

        // R3: count write clears terminal count
        cnt_lo_wr = 1'b1; cnt_wdata = 8'h01;
        @(negedge clk);
        cnt_lo_wr = 1'b0;
        chk("R3 tc cleared by write", stat_o[4], 0);

        // R8 deferral to target completion, then R9
        phase_size = 24'd8;
        wr_cnt(8'd8, 8'd0);
        offer(17'd8);
        issue(8'h90);
        wait_req("R8 req");
        chk("R8 len", mem_len, 8);
        grant();
        repeat (3) @(negedge clk);
        chk("R8 deferred busy", busy_o, 1);
        chk("R8 deferred no irq", irq_o, 0);
        pulse_done();
        chk("R9 status phase", stat_o[2:0], 3);
        chk("R9 tc", stat_o[4], 1);
        chk("R9 irq", irq_o, 1);
        chk("R9 reason", reason_o, 8'h10);
        chk("R9 busy", busy_o, 0);
        chk("R9 count", cnt_rd, 0);
        ack();

        // R5 no buffer, then R11 busy ignores a new start
        phase_size = 24'd4;
        wr_cnt(8'd4, 8'd0);
        issue(8'h90);
        repeat (5) @(negedge clk);
        chk("R5 busy waiting", busy_o, 1);
        chk("R5 no request without buffer", mem_req, 0);
        phase_size = 24'd50;
        wr_cnt(8'h20, 8'd0);
        issue(8'h90);
        offer(17'd100);
        wait_req("R11 req");
        chk("R11 length unchanged", mem_len, 4);
        grant();
        chk("R6 partial buffer completes", irq_o, 1);
        ack();

        // R8 immediate completion, target-to-host with phase left
        phase_size = 24'd10;
        wr_cnt(8'd4, 8'd0);
        offer(17'd4);
        issue(8'h90);
        wait_req("R8 req2");
        grant();
        chk("R8 exhausted with phase left", irq_o, 1);
        chk("R8 busy clear", busy_o, 0);
        ack();

        // R5 multi-chunk host-to-target
        phase_size = 24'hFFFFEC;
        wr_cnt(8'd10, 8'd0);
        offer(17'd4);
        issue(8'h90);
        wait_req("R5 req a");
        chk("R5 first chunk", mem_len, 4);
        chk("R10 to target", mem_store, 0);
        grant();
        chk("R8 to-target waits", busy_o, 1);
        chk("R8 to-target no irq", irq_o, 0);
        offer(17'd8);
        wait_req("R5 req b");
        chk("R5 second chunk", mem_len, 6);
        grant();
        chk("R6 leftover completes", irq_o, 1);
        ack();

        // R8 to-target deferral completed by next offer
        phase_size = 24'hFFFFFA;
        wr_cnt(8'd6, 8'd0);
        offer(17'd6);
        issue(8'h90);
        wait_req("R8 req3");
        grant();
        chk("R8 waits for offer", irq_o, 0);
        offer(17'd3);
        @(negedge clk);
        chk("R8 offer completes", irq_o, 1);
        chk("R8 busy cleared", busy_o, 0);
        chk("R8 reason", reason_o, 8'h10);
        ack();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule